// File: doc/BRIEF.md
# Padded Strided Sliding Window Generator

This block turns a raster-ordered stream of feature-map pixels into square K×K convolution windows, with K = 5 by default. It walks a virtual grid that is the image enlarged by `pad` pixels on every side. At grid positions outside the image it injects zeros, and it pulls no sample from the stream there. Inside the image it consumes one streamed pixel per step. Four line buffers hold the previous padded rows, and a K×K register array shifts one column to the left on every step.

A window is flagged only once enough rows and columns have been scanned to fill it. It is also flagged only at positions that fall on the configured stride in both directions. Each flagged window comes with its output row and column index. A frame is started with a one-cycle `start_i` pulse, which latches the geometry and clears all history. `done_o` reports that the last padded position has been scanned.

Top module: `slide_win_gen`

## Requirements
- R1: For a window flagged at scan position (i, j), element (r, c) sits at bits `[(r*K+c)*DATA_W +: DATA_W]` of `win_o`, with r = 0 the top row and c = 0 the left column. Its value is image pixel (i-K+1+r, j-K+1+c), or zero when that coordinate lies outside the image.
- R2: Scan indices i and j each run from -pad to dim+pad-1. `pix_ready_o` is high only at in-image positions of an active scan. Border positions advance one per cycle whether or not `pix_valid_i` is high, so a frame lasts (W+2·pad)·(H+2·pad) cycles plus the stall cycles.
- R3: When `pix_ready_o` is high and `pix_valid_i` is low, the scan does not advance. In the next cycle no window is flagged and `win_o` is unchanged.
- R4: Each frame consumes exactly W·H samples, in raster order, each on a cycle where `pix_valid_i` and `pix_ready_o` are both high.
- R5: A window is flagged only when i ≥ K-1-pad, j ≥ K-1-pad, (i-(K-1-pad)) mod stride = 0 and (j-(K-1-pad)) mod stride = 0. `win_valid_o` is high for one cycle, the cycle after that position's step. A 6×6 image with pad 2 and stride 2 yields exactly 9 windows.
- R6: `win_row_o` and `win_col_o` give the zero-based index of the flagged window among the flagged rows and the flagged columns of the frame.
- R7: One cycle after `start_i`, `win_o` is all zero, `win_valid_o` and `done_o` are low, and the line buffers are cleared. The width, height, pad and stride are captured at that edge.
- R8: `done_o` rises in the cycle after the last padded position is scanned and stays high until the next `start_i`. `pix_ready_o` is low while `done_o` is high.
- R9: After reset, `win_valid_o`, `done_o` and `pix_ready_o` are low and `win_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Frame start pulse; latches configuration and clears history |
| img_w_i | input | DIM_W | Image width in pixels (1..MAX_DIM) |
| img_h_i | input | DIM_W | Image height in pixels (1..MAX_DIM) |
| pad_i | input | PAD_W | Zero border width on each side (0..K-1) |
| stride_i | input | STRIDE_W | Window stride, at least 1 |
| pix_i | input | DATA_W | Streamed pixel |
| pix_valid_i | input | 1 | Streamed pixel is present |
| pix_ready_o | output | 1 | Pixel is consumed this cycle when valid |
| win_o | output | K*K*DATA_W | Window elements, row-major, element 0 at the top left |
| win_valid_o | output | 1 | `win_o` holds a flagged window |
| win_row_o | output | OUT_W | Output row index of the window |
| win_col_o | output | OUT_W | Output column index of the window |
| done_o | output | 1 | Frame fully scanned |

## Verification
The bench drives frames with pad 0, 1, 2 and 4 and strides 1, 2 and 3. The frames are square and non-square, one is of maximum width, and the input valid signal has gaps. Every flagged window is compared in full against a model that indexes the image directly. A design that fed stale line-buffer data, swapped buffer rows or failed to zero the border would show wrong elements. One that slipped the stride counters would flag extra windows, miss windows or report the wrong indices. Cycle counting per frame catches a design that waits for input at border positions or consumes samples there. Stall cycles are checked for a held window, and a restart frame after a differently sized one exposes history that was not cleared.

// File: rtl/swg_pkg.sv
`timescale 1ns/1ps
package swg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_DONE = 2'd2
  } scan_st_e;
endpackage

// File: rtl/swg_line_bufs.sv
`timescale 1ns/1ps
module swg_line_bufs #(
  parameter int DATA_W = 8,
  parameter int NBUF   = 4,
  parameter int COLS   = 24,
  parameter int COL_AW = 5
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           clr_i,
  input  logic                           wr_i,
  input  logic [COL_AW-1:0]              addr_i,
  input  logic [DATA_W-1:0]              din_i,
  output logic [NBUF-1:0][DATA_W-1:0]    taps_o
);
  // chain[0] is the new sample, chain[b+1] is buffer b at addr_i
  logic [NBUF:0][DATA_W-1:0] chain;
  assign chain[0] = din_i;

  for (genvar gb = 0; gb < NBUF; gb++) begin : g_buf
    logic [DATA_W-1:0] mem_q [COLS];
    assign chain[gb+1] = mem_q[addr_i];
    assign taps_o[gb]  = chain[gb+1];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int c = 0; c < COLS; c++) mem_q[c] <= '0;
      end else if (clr_i) begin
        for (int c = 0; c < COLS; c++) mem_q[c] <= '0;
      end else if (wr_i) begin
        mem_q[addr_i] <= chain[gb];
      end
    end
  end
endmodule

// File: rtl/swg_window.sv
`timescale 1ns/1ps
module swg_window #(
  parameter int DATA_W = 8,
  parameter int K      = 5
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        clr_i,
  input  logic                        shift_i,
  input  logic [K-1:0][DATA_W-1:0]    col_i,
  output logic [K*K*DATA_W-1:0]       win_o
);
  logic [DATA_W-1:0] w_q [K][K];

  for (genvar r = 0; r < K; r++) begin : g_row
    for (genvar c = 0; c < K; c++) begin : g_col
      logic [DATA_W-1:0] nxt;
      if (c < K-1) begin : g_shift
        assign nxt = w_q[r][c+1];
      end else begin : g_fill
        assign nxt = col_i[r];
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      w_q[r][c] <= '0;
        else if (clr_i)   w_q[r][c] <= '0;
        else if (shift_i) w_q[r][c] <= nxt;
      end

      assign win_o[(r*K+c)*DATA_W +: DATA_W] = w_q[r][c];
    end
  end
endmodule

// File: rtl/swg_scan_ctrl.sv
`timescale 1ns/1ps
module swg_scan_ctrl
  import swg_pkg::*;
#(
  parameter int K        = 5,
  parameter int DIM_W    = 5,
  parameter int PAD_W    = 3,
  parameter int STRIDE_W = 3,
  parameter int CW       = 7,
  parameter int COL_AW   = 5,
  parameter int OUT_W    = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [DIM_W-1:0]    img_w_i,
  input  logic [DIM_W-1:0]    img_h_i,
  input  logic [PAD_W-1:0]    pad_i,
  input  logic [STRIDE_W-1:0] stride_i,
  input  logic                pix_valid_i,
  output logic                step_o,
  output logic                border_o,
  output logic                hit_o,
  output logic [COL_AW-1:0]   col_addr_o,
  output logic [OUT_W-1:0]    out_row_o,
  output logic [OUT_W-1:0]    out_col_o,
  output logic                ready_o,
  output logic                done_o
);
  localparam logic signed [CW-1:0] ONE = CW'(1);
  localparam logic signed [CW-1:0] KM1 = CW'(K-1);
  localparam logic [STRIDE_W:0]    S1  = (STRIDE_W+1)'(1);
  localparam logic [OUT_W-1:0]     O1  = OUT_W'(1);

  scan_st_e st_q;
  logic [DIM_W-1:0]    w_q, h_q;
  logic [PAD_W-1:0]    pad_q;
  logic [STRIDE_W-1:0] str_q, cs_q, rs_q;
  logic signed [CW-1:0] i_q, j_q;
  logic [OUT_W-1:0]    oc_q, or_q;

  logic signed [CW-1:0] w_s, h_s, p_s, p_in_s, thr_s;
  logic scanning, col_ok, row_ok, col_end, row_last;
  logic [STRIDE_W:0] cs_inc, rs_inc;
  logic [STRIDE_W-1:0] cs_wrap, rs_wrap;

  assign w_s    = signed'(CW'(w_q));
  assign h_s    = signed'(CW'(h_q));
  assign p_s    = signed'(CW'(pad_q));
  assign p_in_s = signed'(CW'(pad_i));
  assign thr_s  = KM1 - p_s;

  assign scanning = (st_q == ST_SCAN);
  assign border_o = i_q[CW-1] || j_q[CW-1] || (i_q >= h_s) || (j_q >= w_s);
  assign ready_o  = scanning && !border_o;
  assign step_o   = scanning && (border_o || pix_valid_i);
  assign col_ok   = (j_q >= thr_s);
  assign row_ok   = (i_q >= thr_s);
  assign col_end  = (j_q == w_s + p_s - ONE);
  assign row_last = (i_q == h_s + p_s - ONE);
  assign hit_o    = step_o && col_ok && row_ok && (cs_q == '0) && (rs_q == '0);
  assign col_addr_o = COL_AW'(j_q + p_s);
  assign out_row_o  = or_q;
  assign out_col_o  = oc_q;
  assign done_o     = (st_q == ST_DONE);

  // stride counters stay in 0..stride-1
  assign cs_inc  = {1'b0, cs_q} + S1;
  assign rs_inc  = {1'b0, rs_q} + S1;
  assign cs_wrap = (cs_inc == {1'b0, str_q}) ? '0 : cs_inc[STRIDE_W-1:0];
  assign rs_wrap = (rs_inc == {1'b0, str_q}) ? '0 : rs_inc[STRIDE_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      w_q   <= '0;
      h_q   <= '0;
      pad_q <= '0;
      str_q <= '0;
      i_q   <= '0;
      j_q   <= '0;
      cs_q  <= '0;
      rs_q  <= '0;
      oc_q  <= '0;
      or_q  <= '0;
    end else if (start_i) begin
      st_q  <= ST_SCAN;
      w_q   <= img_w_i;
      h_q   <= img_h_i;
      pad_q <= pad_i;
      str_q <= stride_i;
      i_q   <= -p_in_s;
      j_q   <= -p_in_s;
      cs_q  <= '0;
      rs_q  <= '0;
      oc_q  <= '0;
      or_q  <= '0;
    end else if (step_o) begin
      if (col_end) begin
        j_q  <= -p_s;
        i_q  <= i_q + ONE;
        cs_q <= '0;
        oc_q <= '0;
        if (row_ok) rs_q <= rs_wrap;
        if (row_ok && rs_q == '0) or_q <= or_q + O1;
        if (row_last) st_q <= ST_DONE;
      end else begin
        j_q <= j_q + ONE;
        if (col_ok) cs_q <= cs_wrap;
        if (hit_o)  oc_q <= oc_q + O1;
      end
    end
  end
endmodule

// File: rtl/slide_win_gen.sv
`timescale 1ns/1ps
module slide_win_gen #(
  parameter  int DATA_W   = 8,
  parameter  int K        = 5,
  parameter  int MAX_DIM  = 16,
  parameter  int STRIDE_W = 3,
  localparam int DIM_W    = $clog2(MAX_DIM + 1),
  localparam int PAD_W    = $clog2(K),
  localparam int OUT_W    = $clog2(MAX_DIM + K),
  localparam int WIN_W    = K * K * DATA_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [DIM_W-1:0]    img_w_i,
  input  logic [DIM_W-1:0]    img_h_i,
  input  logic [PAD_W-1:0]    pad_i,
  input  logic [STRIDE_W-1:0] stride_i,
  input  logic [DATA_W-1:0]   pix_i,
  input  logic                pix_valid_i,
  output logic                pix_ready_o,
  output logic [WIN_W-1:0]    win_o,
  output logic                win_valid_o,
  output logic [OUT_W-1:0]    win_row_o,
  output logic [OUT_W-1:0]    win_col_o,
  output logic                done_o
);
  localparam int NBUF   = K - 1;
  localparam int COLS   = MAX_DIM + 2 * (K - 1);
  localparam int COL_AW = $clog2(COLS);
  localparam int CW     = $clog2(MAX_DIM + 2 * K) + 2;

  logic                          step, border, hit;
  logic [COL_AW-1:0]             col_addr;
  logic [OUT_W-1:0]              out_row, out_col;
  logic [DATA_W-1:0]             sample;
  logic [NBUF-1:0][DATA_W-1:0]   taps;
  logic [K-1:0][DATA_W-1:0]      new_col;
  logic                          win_valid_q;
  logic [OUT_W-1:0]              row_q, col_q;

  swg_scan_ctrl #(
    .K(K), .DIM_W(DIM_W), .PAD_W(PAD_W), .STRIDE_W(STRIDE_W),
    .CW(CW), .COL_AW(COL_AW), .OUT_W(OUT_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .img_w_i     (img_w_i),
    .img_h_i     (img_h_i),
    .pad_i       (pad_i),
    .stride_i    (stride_i),
    .pix_valid_i (pix_valid_i),
    .step_o      (step),
    .border_o    (border),
    .hit_o       (hit),
    .col_addr_o  (col_addr),
    .out_row_o   (out_row),
    .out_col_o   (out_col),
    .ready_o     (pix_ready_o),
    .done_o      (done_o)
  );

  assign sample = border ? '0 : pix_i;

  swg_line_bufs #(
    .DATA_W(DATA_W), .NBUF(NBUF), .COLS(COLS), .COL_AW(COL_AW)
  ) u_lbuf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_i),
    .wr_i   (step),
    .addr_i (col_addr),
    .din_i  (sample),
    .taps_o (taps)
  );

  // bottom row takes the sample, upper rows take progressively older buffers
  for (genvar r = 0; r < K - 1; r++) begin : g_col
    assign new_col[r] = taps[K-2-r];
  end
  assign new_col[K-1] = sample;

  swg_window #(.DATA_W(DATA_W), .K(K)) u_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (start_i),
    .shift_i (step),
    .col_i   (new_col),
    .win_o   (win_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_valid_q <= 1'b0;
      row_q       <= '0;
      col_q       <= '0;
    end else if (start_i) begin
      win_valid_q <= 1'b0;
      row_q       <= '0;
      col_q       <= '0;
    end else begin
      win_valid_q <= hit;
      if (hit) begin
        row_q <= out_row;
        col_q <= out_col;
      end
    end
  end

  assign win_valid_o = win_valid_q;
  assign win_row_o   = row_q;
  assign win_col_o   = col_q;
endmodule

// File: rtl/swg_checker.sv
`timescale 1ns/1ps
module swg_checker #(
  parameter int WIN_W = 200
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             pix_valid_i,
  input logic             pix_ready_o,
  input logic [WIN_W-1:0] win_o,
  input logic             win_valid_o,
  input logic             done_o
);
  p_start_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (win_o == '0 && !win_valid_o && !done_o));

  p_stall_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_ready_o && !pix_valid_i && !start_i) |=> (!win_valid_o && $stable(win_o)));

  p_done_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);

  p_no_ready_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !pix_ready_o);
endmodule

bind slide_win_gen swg_checker #(.WIN_W(WIN_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .pix_valid_i (pix_valid_i),
  .pix_ready_o (pix_ready_o),
  .win_o       (win_o),
  .win_valid_o (win_valid_o),
  .done_o      (done_o)
);

// File: tb/tb_slide_win_gen.sv
`timescale 1ns/1ps
module tb_slide_win_gen;
  localparam int DATA_W   = 8;
  localparam int K        = 5;
  localparam int MAX_DIM  = 16;
  localparam int STRIDE_W = 3;
  localparam int DIM_W    = $clog2(MAX_DIM + 1);
  localparam int PAD_W    = $clog2(K);
  localparam int OUT_W    = $clog2(MAX_DIM + K);
  localparam int WIN_W    = K * K * DATA_W;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b1;
  logic start_i = 1'b0;
  logic [DIM_W-1:0] img_w_i = '0, img_h_i = '0;
  logic [PAD_W-1:0] pad_i = '0;
  logic [STRIDE_W-1:0] stride_i = '0;
  logic [DATA_W-1:0] pix_i = '0;
  logic pix_valid_i = 1'b0;
  logic pix_ready_o, win_valid_o, done_o;
  logic [WIN_W-1:0] win_o;
  logic [OUT_W-1:0] win_row_o, win_col_o;

  always #2.5 clk_i = ~clk_i;

  slide_win_gen #(.DATA_W(DATA_W), .K(K), .MAX_DIM(MAX_DIM), .STRIDE_W(STRIDE_W)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .img_w_i(img_w_i), .img_h_i(img_h_i), .pad_i(pad_i), .stride_i(stride_i),
    .pix_i(pix_i), .pix_valid_i(pix_valid_i), .pix_ready_o(pix_ready_o),
    .win_o(win_o), .win_valid_o(win_valid_o),
    .win_row_o(win_row_o), .win_col_o(win_col_o), .done_o(done_o)
  );

  int checks = 0;
  int errors = 0;
  logic [DATA_W-1:0] img [MAX_DIM*MAX_DIM];
  logic [WIN_W-1:0] exp_win_q [$];
  int exp_row_q [$];
  int exp_col_q [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [WIN_W-1:0] act, input logic [WIN_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] pix_at(int r, int c, int w, int h);
    if (r < 0 || r >= h || c < 0 || c >= w) return '0;
    return img[r*w+c];
  endfunction

  // reference: direct indexing of the image, no line buffers
  task automatic build_expect(int w, int h, int p, int s);
    int t = K - 1 - p;
    int orow = 0;
    exp_win_q.delete(); exp_row_q.delete(); exp_col_q.delete();
    for (int i = -p; i < h + p; i++) begin
      if (i >= t && (i - t) % s == 0) begin
        int ocol = 0;
        for (int j = -p; j < w + p; j++) begin
          if (j >= t && (j - t) % s == 0) begin
            logic [WIN_W-1:0] e = '0;
            for (int r = 0; r < K; r++)
              for (int c = 0; c < K; c++)
                e[(r*K+c)*DATA_W +: DATA_W] = pix_at(i-K+1+r, j-K+1+c, w, h);
            exp_win_q.push_back(e);
            exp_row_q.push_back(orow);
            exp_col_q.push_back(ocol);
            ocol++;
          end
        end
        orow++;
      end
    end
  endtask

  task automatic run_frame(int w, int h, int p, int s, int stall_pct, int want_cnt);
    int nexp, got, idx, cycles, stalls;
    bit prev_stall, fire;
    logic [WIN_W-1:0] prev_win;
    build_expect(w, h, p, s);
    nexp = exp_win_q.size();
    @(negedge clk_i);
    start_i = 1'b1; img_w_i = DIM_W'(w); img_h_i = DIM_W'(h);
    pad_i = PAD_W'(p); stride_i = STRIDE_W'(s); pix_valid_i = 1'b0;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    // R7: cleared state right after start
    chk(win_o == '0 && !win_valid_o && !done_o, "R7", "state after start",
        {win_valid_o, done_o, win_o}, '0);
    got = 0; idx = 0; cycles = 0; stalls = 0; prev_stall = 0; prev_win = '0;
    while (cycles < 20000) begin
      if (prev_stall)
        chk(!win_valid_o && win_o == prev_win, "R3", "stall holds window",
            win_o, prev_win);
      if (win_valid_o) begin
        if (exp_win_q.size() == 0) begin
          chk(0, "R5", "unexpected window", WIN_W'(got), WIN_W'(nexp));
        end else begin
          logic [WIN_W-1:0] ew = exp_win_q.pop_front();
          int er = exp_row_q.pop_front();
          int ec = exp_col_q.pop_front();
          chk(win_o == ew, "R1", "window contents", win_o, ew);
          chk(int'(win_row_o) == er && int'(win_col_o) == ec, "R6", "row/col index",
              {win_row_o, win_col_o}, {OUT_W'(er), OUT_W'(ec)});
        end
        got++;
      end
      if (done_o) break;
      pix_valid_i = (($urandom % 100) >= stall_pct);
      pix_i = (idx < w*h) ? img[idx] : '0;
      #1;
      prev_stall = pix_ready_o && !pix_valid_i;
      if (prev_stall) stalls++;
      fire = pix_ready_o && pix_valid_i;
      prev_win = win_o;
      @(posedge clk_i);
      if (fire) idx++;
      cycles++;
      @(negedge clk_i);
    end
    pix_valid_i = 1'b0;
    if (cycles >= 20000) chk(0, "R8", "frame watchdog", WIN_W'(cycles), '0);
    chk(got == nexp, "R5", "window count", WIN_W'(got), WIN_W'(nexp));
    if (want_cnt > 0)
      chk(got == want_cnt, "R5", "reference frame window count", WIN_W'(got), WIN_W'(want_cnt));
    chk(idx == w*h, "R4", "samples consumed", WIN_W'(idx), WIN_W'(w*h));
    chk(cycles == (w+2*p)*(h+2*p) + stalls, "R2", "scan cycle count",
        WIN_W'(cycles), WIN_W'((w+2*p)*(h+2*p) + stalls));
    repeat (3) @(negedge clk_i);
    chk(done_o && !pix_ready_o && !win_valid_o, "R8", "done held, ready low",
        {done_o, pix_ready_o, win_valid_o}, {1'b1, 1'b0, 1'b0});
  endtask

  task automatic fill_random(int n);
    for (int k = 0; k < n; k++) img[k] = DATA_W'($urandom);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1 rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    // R9: reset state
    chk(!win_valid_o && !done_o && !pix_ready_o && win_o == '0, "R9", "reset state",
        {win_valid_o, done_o, pix_ready_o, win_o}, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // reference 6x6 case, pixel = 10 + row + col
    for (int r = 0; r < 6; r++)
      for (int c = 0; c < 6; c++) img[r*6+c] = DATA_W'(10 + r + c);
    run_frame(6, 6, 2, 2, 0, 9);

    fill_random(35);
    run_frame(7, 5, 0, 1, 30, 0);

    fill_random(48);
    run_frame(8, 6, 1, 3, 20, 0);

    fill_random(9);
    run_frame(3, 3, 4, 1, 50, 0);

    fill_random(256);
    run_frame(16, 16, 2, 2, 10, 0);

    // restart with new data: no history may leak
    for (int r = 0; r < 6; r++)
      for (int c = 0; c < 6; c++) img[r*6+c] = DATA_W'(200 - r*7 + c);
    run_frame(6, 6, 2, 2, 25, 9);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule